// File: doc/BRIEF.md
# Vertical Sequence Timing Generator

This block produces the per-line vertical shift timing for an image sensor readout. A pixel counter runs across each line and raises a one-clock horizontal-drive pulse at pixel 0. At a start pixel that depends on line parity, four pattern engines play their stored vertical pattern groups back to back a programmed number of times. Each bank of six vertical outputs follows whichever group its select field names. The clamp, pixel-blanking and horizontal-blanking outputs are drawn from a start level and two toggle pixels each.

All settings arrive through a single-cycle register write port. Writes land in a pending copy. The whole pending copy, including the pattern table, moves into the working copy only when a new line begins. A field-start strobe restarts the line and forces odd parity. A last-line input, sampled when a line begins, selects a separate length for that line. Two freeze windows, gated by a mask enable, hold the vertical outputs at their current levels.

Top module: `vseq_timing_gen`

## Requirements
- R1: While reset is applied, `hd` is 1 and `v_out`, `clamp`, `pblk` and `hblk` are all 0.
- R2: `hd` is 1 only at pixel 0. The counter wraps after pixel L-1, where L is the line length at address 0x000, bits [12:0].
- R3: If `last_line` is 1 in the cycle a line begins, that line uses the length at address 0x001, bits [12:0], in place of the normal length.
- R4: `field_start` makes the next cycle pixel 0 of an odd line, and parity flips on every later line. Odd lines take their start pixel from 0x002 and their play count from 0x004, bits [3:0]. Even lines use 0x003 and 0x005 instead.
- R5: Pattern group g has its length at 0x010+g. Entry 0x100 + 32*g + o holds t1 in [12:0], t2 in [28:16] and level in [31]. During play at phase p, output o is level ^ (p>=t1) ^ (p>=t2). Play k covers pixels start + k*len to start + (k+1)*len - 1. Outside play, the output sits at its level.
- R6: Address 0x006 holds a 2-bit group select for each bank of six outputs. Bank b (outputs 6b to 6b+5) uses bits [2b+1:2b].
- R7: A play count of 0 suppresses the pattern for that line, so every vertical output stays at its level.
- R8: Address 0x007 holds mask enable in bit 0, window-1 enable in bit 1 and window-2 enable in bit 2. Window w has its freeze pixel at 0x008+2(w-1) and its resume pixel at 0x009+2(w-1). From the freeze pixel up to, but not including, the resume pixel, `v_out` holds the value it had just before the window.
- R9: Addresses 0x00C, 0x00D and 0x00E drive `clamp`, `pblk` and `hblk`. Each uses the R5 field layout, evaluated at the current pixel.
- R10: A write never changes the line in progress. It takes effect from the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | Restart line at odd parity |
| last_line | input | 1 | Next line uses last-line length |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register write address |
| wr_data | input | 32 | Register write data |
| hd | output | 1 | Horizontal-drive pulse at pixel 0 |
| v_out | output | 24 | Vertical outputs |
| clamp | output | 1 | Clamp pulse |
| pblk | output | 1 | Pixel blanking |
| hblk | output | 1 | Horizontal blanking |

## Verification
The four pattern groups get lengths 6, 4, 5 and 3 and are mapped to separate banks, so a wrong bank-to-group mapping or a wrong repeat boundary shows up at once. The bench steps through odd and even lines with play counts of 2 and 3. This separates the parity choice of start pixel and play count, and a shortened last line cuts a play partway through. Further lines cover freezes in the middle of a play (one window at a time), a mid-line field restart that forces odd parity twice in a row, and a play count of zero. Mid-line writes confirm the line in progress keeps its old length and mask.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int PIX_W    = 13;
  localparam int NUM_V    = 24;
  localparam int NUM_PAT  = 4;
  localparam int NUM_BANK = 4;
  localparam int NUM_WIN  = 2;
  localparam int REP_W    = 4;
  localparam int ADDR_W   = 9;
  localparam int DATA_W   = 32;
  localparam int T2_LSB   = 16;

  localparam int PSEL_W  = $clog2(NUM_PAT);
  localparam int BANK_SZ = NUM_V / NUM_BANK;
  localparam int PAT_ENT = NUM_PAT * NUM_V;
  localparam int OUT_AW  = $clog2(NUM_V);
  localparam int LOW_W   = ADDR_W - 1;
  localparam int PIDX_W  = ADDR_W - 1 - OUT_AW;

  localparam int AD_LEN   = 0;
  localparam int AD_LAST  = 1;
  localparam int AD_STA   = 2;
  localparam int AD_STB   = 3;
  localparam int AD_REPO  = 4;
  localparam int AD_REPE  = 5;
  localparam int AD_PSEL  = 6;
  localparam int AD_MASK  = 7;
  localparam int AD_WIN   = 8;
  localparam int AD_CLAMP = 12;
  localparam int AD_PBLK  = 13;
  localparam int AD_HBLK  = 14;
  localparam int AD_GLEN  = 16;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    logic lvl;
    pix_t t2;
    pix_t t1;
  } edge_t;

  typedef struct packed {
    pix_t                           line_len;
    pix_t                           last_len;
    pix_t                           start_a;
    pix_t                           start_b;
    logic [REP_W-1:0]               rep_odd;
    logic [REP_W-1:0]               rep_even;
    logic [NUM_BANK-1:0][PSEL_W-1:0] psel;
    logic                           mask_en;
    logic [NUM_WIN-1:0]             win_en;
    logic [NUM_WIN-1:0][PIX_W-1:0]  frz;
    logic [NUM_WIN-1:0][PIX_W-1:0]  res;
    edge_t                          clamp;
    edge_t                          pblk;
    edge_t                          hblk;
    logic [NUM_PAT-1:0][PIX_W-1:0]  glen;
  } cfg_t;

  function automatic edge_t unpack_edge(input logic [DATA_W-1:0] d);
    edge_t e;
    e.lvl = d[DATA_W-1];
    e.t2  = d[T2_LSB +: PIX_W];
    e.t1  = d[0 +: PIX_W];
    return e;
  endfunction

  function automatic logic edge_level(input edge_t e, input pix_t p);
    return e.lvl ^ (p >= e.t1) ^ (p >= e.t2);
  endfunction
endpackage

// File: rtl/vseq_regfile.sv
module vseq_regfile
  import vseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output cfg_t              pend_cfg,
  output cfg_t              act_cfg,
  output edge_t             act_pat [PAT_ENT]
);
  cfg_t             cfg_w;
  logic [LOW_W-1:0] low;
  logic             reg_sel;

  assign low     = wr_addr[LOW_W-1:0];
  assign reg_sel = wr_en && !wr_addr[ADDR_W-1];

  always_comb begin
    cfg_w = pend_cfg;
    if (reg_sel) begin
      case (low)
        LOW_W'(AD_LEN):   cfg_w.line_len = wr_data[PIX_W-1:0];
        LOW_W'(AD_LAST):  cfg_w.last_len = wr_data[PIX_W-1:0];
        LOW_W'(AD_STA):   cfg_w.start_a  = wr_data[PIX_W-1:0];
        LOW_W'(AD_STB):   cfg_w.start_b  = wr_data[PIX_W-1:0];
        LOW_W'(AD_REPO):  cfg_w.rep_odd  = wr_data[REP_W-1:0];
        LOW_W'(AD_REPE):  cfg_w.rep_even = wr_data[REP_W-1:0];
        LOW_W'(AD_PSEL):  begin
          for (int b = 0; b < NUM_BANK; b++)
            cfg_w.psel[b] = wr_data[b*PSEL_W +: PSEL_W];
        end
        LOW_W'(AD_MASK):  begin
          cfg_w.mask_en = wr_data[0];
          cfg_w.win_en  = wr_data[1 +: NUM_WIN];
        end
        LOW_W'(AD_CLAMP): cfg_w.clamp = unpack_edge(wr_data);
        LOW_W'(AD_PBLK):  cfg_w.pblk  = unpack_edge(wr_data);
        LOW_W'(AD_HBLK):  cfg_w.hblk  = unpack_edge(wr_data);
        default: ;
      endcase
      for (int w = 0; w < NUM_WIN; w++) begin
        if (low == LOW_W'(AD_WIN + 2*w))     cfg_w.frz[w] = wr_data[PIX_W-1:0];
        if (low == LOW_W'(AD_WIN + 2*w + 1)) cfg_w.res[w] = wr_data[PIX_W-1:0];
      end
      for (int g = 0; g < NUM_PAT; g++)
        if (low == LOW_W'(AD_GLEN + g)) cfg_w.glen[g] = wr_data[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cfg <= '0;
      act_cfg  <= '0;
    end else begin
      pend_cfg <= cfg_w;
      if (load) act_cfg <= pend_cfg;
    end
  end

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    for (genvar o = 0; o < NUM_V; o++) begin : g_out
      localparam int IDX = g*NUM_V + o;
      logic  hit;
      edge_t pend_e;
      edge_t pend_e_n;

      assign hit = wr_en && wr_addr[ADDR_W-1]
                && (wr_addr[ADDR_W-2:OUT_AW] == PIDX_W'(g))
                && (wr_addr[OUT_AW-1:0] == OUT_AW'(o));
      assign pend_e_n = hit ? unpack_edge(wr_data) : pend_e;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_e       <= '0;
          act_pat[IDX] <= '0;
        end else begin
          pend_e <= pend_e_n;
          if (load) act_pat[IDX] <= pend_e;
        end
      end
    end
  end
endmodule

// File: rtl/vseq_line_ctr.sv
module vseq_line_ctr
  import vseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic field_start,
  input  logic last_line,
  input  pix_t pend_line_len,
  input  pix_t pend_last_len,
  output pix_t cnt,
  output pix_t cnt_n,
  output pix_t line_len_q,
  output logic load,
  output logic par_odd,
  output logic par_odd_n
);
  pix_t len_n;

  always_comb begin
    load      = field_start || (cnt == line_len_q - 1'b1);
    cnt_n     = load ? '0 : cnt + 1'b1;
    par_odd_n = field_start ? 1'b1 : (load ? ~par_odd : par_odd);
    len_n     = line_len_q;
    if (load) len_n = last_line ? pend_last_len : pend_line_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      line_len_q <= '0;
      par_odd    <= 1'b1;
    end else begin
      cnt        <= cnt_n;
      line_len_q <= len_n;
      par_odd    <= par_odd_n;
    end
  end
endmodule

// File: rtl/vseq_pat_engine.sv
module vseq_pat_engine
  import vseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  pix_t             cnt_n,
  input  pix_t             start_n,
  input  pix_t             glen_n,
  input  logic [REP_W-1:0] plays_n,
  output logic             active,
  output pix_t             pos
);
  logic [REP_W-1:0] rep_q;
  logic [REP_W-1:0] rep_n;
  logic             act_n;
  pix_t             pos_n;

  always_comb begin
    act_n = active;
    pos_n = pos;
    rep_n = rep_q;
    if ((cnt_n == start_n) && (plays_n != '0)) begin
      act_n = 1'b1;
      pos_n = '0;
      rep_n = '0;
    end else if (load) begin
      act_n = 1'b0;
    end else if (active) begin
      if (pos == glen_n - 1'b1) begin
        pos_n = '0;
        if (rep_q == plays_n - 1'b1) act_n = 1'b0;
        else                         rep_n = rep_q + 1'b1;
      end else begin
        pos_n = pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      rep_q  <= '0;
    end else begin
      active <= act_n;
      pos    <= pos_n;
      rep_q  <= rep_n;
    end
  end
endmodule

// File: rtl/vseq_timing_gen.sv
module vseq_timing_gen
  import vseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              last_line,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hd,
  output logic [NUM_V-1:0]  v_out,
  output logic              clamp,
  output logic              pblk,
  output logic              hblk
);
  logic [1:0]         rst_sr;
  logic               rst_sync_n;
  pix_t               cnt;
  pix_t               cnt_n;
  pix_t               line_len_q;
  logic               line_load;
  logic               par_odd;
  logic               par_odd_n;
  cfg_t               pend_cfg;
  cfg_t               act_cfg;
  cfg_t               cfg_next;
  edge_t              act_pat [PAT_ENT];
  pix_t               start_n;
  logic [REP_W-1:0]   plays_n;
  logic [NUM_PAT-1:0] eng_act;
  pix_t               eng_pos [NUM_PAT];
  logic [NUM_V-1:0]   v_raw;
  logic [NUM_V-1:0]   v_hold;
  logic               frozen;
  logic [PSEL_W-1:0]  sel;
  edge_t              ent;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_sync_n = rst_sr[1];

  vseq_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load     (line_load),
    .pend_cfg (pend_cfg),
    .act_cfg  (act_cfg),
    .act_pat  (act_pat)
  );

  vseq_line_ctr u_line (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .field_start   (field_start),
    .last_line     (last_line),
    .pend_line_len (pend_cfg.line_len),
    .pend_last_len (pend_cfg.last_len),
    .cnt           (cnt),
    .cnt_n         (cnt_n),
    .line_len_q    (line_len_q),
    .load          (line_load),
    .par_odd       (par_odd),
    .par_odd_n     (par_odd_n)
  );

  // settings that govern the coming cycle
  always_comb begin
    cfg_next = line_load ? pend_cfg : act_cfg;
    start_n  = par_odd_n ? cfg_next.start_a : cfg_next.start_b;
    plays_n  = par_odd_n ? cfg_next.rep_odd : cfg_next.rep_even;
  end

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_eng
    vseq_pat_engine u_eng (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load    (line_load),
      .cnt_n   (cnt_n),
      .start_n (start_n),
      .glen_n  (cfg_next.glen[g]),
      .plays_n (plays_n),
      .active  (eng_act[g]),
      .pos     (eng_pos[g])
    );
  end

  always_comb begin
    v_raw = '0;
    sel   = '0;
    ent   = '0;
    for (int o = 0; o < NUM_V; o++) begin
      sel      = act_cfg.psel[o / BANK_SZ];
      ent      = act_pat[int'(sel) * NUM_V + o];
      v_raw[o] = eng_act[sel] ? edge_level(ent, eng_pos[sel]) : ent.lvl;
    end
  end

  always_comb begin
    frozen = 1'b0;
    for (int w = 0; w < NUM_WIN; w++)
      if (act_cfg.win_en[w] && (cnt >= act_cfg.frz[w]) && (cnt < act_cfg.res[w]))
        frozen = 1'b1;
    frozen = frozen && act_cfg.mask_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  v_hold <= '0;
    else if (!frozen) v_hold <= v_raw;
  end

  assign v_out = frozen ? v_hold : v_raw;
  assign hd    = (cnt == '0);
  assign clamp = edge_level(act_cfg.clamp, cnt);
  assign pblk  = edge_level(act_cfg.pblk, cnt);
  assign hblk  = edge_level(act_cfg.hblk, cnt);
endmodule

// File: rtl/vseq_timing_gen_chk.sv
module vseq_timing_gen_chk
  import vseq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               field_start,
  input logic               last_line,
  input logic [NUM_V-1:0]   v_out,
  input pix_t               cnt,
  input pix_t               line_len_q,
  input logic               par_odd,
  input logic               frozen,
  input logic               line_load,
  input pix_t               pend_last_len,
  input cfg_t               act_cfg,
  input logic [NUM_PAT-1:0] eng_act
);
  logic [REP_W-1:0] cur_plays;
  assign cur_plays = par_odd ? act_cfg.rep_odd : act_cfg.rep_even;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_len_q != '0) |-> (cnt < line_len_q));

  // R3
  last_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_load && last_line) |=> (line_len_q == $past(pend_last_len)));

  // R4
  field_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> ((cnt == '0) && par_odd));

  // R7
  zero_plays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_plays == '0) |-> (eng_act == '0));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (v_out == $past(v_out)));

  // R10
  cfg_line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_load |=> $stable(act_cfg));
endmodule

bind vseq_timing_gen vseq_timing_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .field_start   (field_start),
  .last_line     (last_line),
  .v_out         (v_out),
  .cnt           (cnt),
  .line_len_q    (line_len_q),
  .par_odd       (par_odd),
  .frozen        (frozen),
  .line_load     (line_load),
  .pend_last_len (pend_cfg.last_len),
  .act_cfg       (act_cfg),
  .eng_act       (eng_act)
);

// File: tb/vseq_timing_gen_tb.sv
`timescale 1ns/1ps
module vseq_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        field_start;
  logic        last_line;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic        hd;
  logic [23:0] v_out;
  logic        clamp, pblk, hblk;

  always #2 clk = ~clk;

  vseq_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .last_line(last_line),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hd(hd), .v_out(v_out),
    .clamp(clamp), .pblk(pblk), .hblk(hblk)
  );

  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;
  logic [31:0] pend [20];
  logic [31:0] cur  [20];
  logic [23:0] exp_hold;
  bit          this_last;
  logic [8:0]  wq_a [3];
  logic [31:0] wq_d [3];

  // line walk table: [9] odd expected, [8] last flag of the following line, [7:0] length
  localparam logic [9:0] LTAB [5] = '{
    {1'b1, 1'b0, 8'd40},
    {1'b0, 1'b0, 8'd40},
    {1'b1, 1'b1, 8'd40},
    {1'b0, 1'b0, 8'd24},
    {1'b1, 1'b0, 8'd40}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, a, e);
    end
  endtask

  function automatic bit edge_m(input logic [31:0] r, input int c);
    return r[31] ^ (c >= int'(r[12:0])) ^ (c >= int'(r[28:16]));
  endfunction

  function automatic bit frz_m(input int c);
    bit f1, f2;
    f1 = cur[7][1] && c >= int'(cur[8][12:0])  && c < int'(cur[9][12:0]);
    f2 = cur[7][2] && c >= int'(cur[10][12:0]) && c < int'(cur[11][12:0]);
    return cur[7][0] && (f1 || f2);
  endfunction

  // expected raw vertical level from R5, R6, R4, R7
  function automatic logic [23:0] v_model(input int c, input bit odd);
    logic [23:0] v;
    for (int o = 0; o < 24; o++) begin
      int g, s, n, len, t1, t2, pos;
      bit lvl;
      g   = int'((cur[6] >> (2*(o/6))) & 32'd3);
      s   = odd ? int'(cur[2][12:0]) : int'(cur[3][12:0]);
      n   = odd ? int'(cur[4][3:0])  : int'(cur[5][3:0]);
      len = int'(cur[16+g][12:0]);
      lvl = bit'(o % 2);
      t1  = o % 3;
      t2  = t1 + 2;
      if (n > 0 && c >= s && c < s + n*len) begin
        pos  = (c - s) % len;
        v[o] = lvl ^ (pos >= t1) ^ (pos >= t2);
      end else begin
        v[o] = lvl;
      end
    end
    return v;
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 9'd20) pend[a] = d;
  endtask

  task automatic run_line(input bit odd, input bit next_last, input int len_tab,
                          input int fs_pix, input string req, input int nw);
    int len;
    logic [23:0] ev;
    for (int i = 0; i < 20; i++) cur[i] = pend[i];
    len = (len_tab > 0) ? len_tab : (this_last ? int'(pend[1][12:0]) : int'(pend[0][12:0]));
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      chk(hd == (c == 0), "R2/R3", $sformatf("hd at pixel %0d", c), 32'(hd), 32'(c == 0));
      ev       = frz_m(c) ? exp_hold : v_model(c, odd);
      exp_hold = ev;
      chk(v_out == ev, req, $sformatf("v_out at pixel %0d", c), 32'(v_out), 32'(ev));
      chk({clamp, pblk, hblk} == {edge_m(cur[12], c), edge_m(cur[13], c), edge_m(cur[14], c)},
          "R9", $sformatf("clamp/pblk/hblk at pixel %0d", c), 32'({clamp, pblk, hblk}),
          32'({edge_m(cur[12], c), edge_m(cur[13], c), edge_m(cur[14], c)}));
      wr_en = 1'b0;
      field_start = 1'b0;
      if (c >= 10 && c <= 14 && (c % 2 == 0) && ((c - 10) / 2) < nw) begin
        wr_en   = 1'b1;
        wr_addr = wq_a[(c-10)/2];
        wr_data = wq_d[(c-10)/2];
        pend[wq_a[(c-10)/2]] = wq_d[(c-10)/2];
      end
      if (c == len - 1 || c == fs_pix) begin
        last_line = next_last;
        this_last = next_last;
      end
      if (c == fs_pix) begin
        field_start = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; field_start = 1'b0; last_line = 1'b0; this_last = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; exp_hold = '0;
    for (int i = 0; i < 20; i++) pend[i] = '0;

    // R1: state while reset is held
    repeat (3) @(negedge clk);
    chk(hd == 1'b1, "R1", "hd in reset", 32'(hd), 32'd1);
    chk(v_out == 24'd0, "R1", "v_out in reset", 32'(v_out), 32'd0);
    chk({clamp, pblk, hblk} == 3'b000, "R1", "edges in reset", 32'({clamp, pblk, hblk}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    wr(9'h000, 32'd40);
    wr(9'h001, 32'd24);
    wr(9'h002, 32'd5);
    wr(9'h003, 32'd8);
    wr(9'h004, 32'd2);
    wr(9'h005, 32'd3);
    wr(9'h006, 32'hE4);
    wr(9'h007, 32'd3);
    wr(9'h008, 32'd12);
    wr(9'h009, 32'd15);
    wr(9'h00A, 32'd14);
    wr(9'h00B, 32'd18);
    wr(9'h00C, (32'd10 << 16) | 32'd2);
    wr(9'h00D, 32'h8000_0000 | (32'd39 << 16) | 32'd38);
    wr(9'h00E, (32'd35 << 16) | 32'd20);
    wr(9'h010, 32'd6);
    wr(9'h011, 32'd4);
    wr(9'h012, 32'd5);
    wr(9'h013, 32'd3);
    for (int g = 0; g < 4; g++)
      for (int o = 0; o < 24; o++)
        wr(9'h100 | 9'(g << 5) | 9'(o),
           (32'(o % 2) << 31) | (32'((o % 3) + 2) << 16) | 32'(o % 3));

    // R4: field start opens an odd line
    @(negedge clk);
    field_start = 1'b1;

    // table walk: parity alternation (R4), patterns (R5, R6), last line (R3), freeze 1 (R8)
    for (int i = 0; i < 5; i++)
      run_line(LTAB[i][9], LTAB[i][8], int'(LTAB[i][7:0]), -1, "R5/R6/R8", 0);

    // R10: mid-line writes leave this even line alone
    wq_a[0] = 9'h000; wq_d[0] = 32'd30;
    wq_a[1] = 9'h007; wq_d[1] = 32'd5;
    wq_a[2] = 9'h005; wq_d[2] = 32'd0;
    run_line(1'b0, 1'b0, 40, -1, "R10", 3);
    // R8: window 2 alone freezes a play; field restart at pixel 20
    run_line(1'b1, 1'b0, -1, 20, "R8", 0);
    // R4: restart gives odd again
    run_line(1'b1, 1'b0, -1, -1, "R4", 0);
    // R7: even line with play count 0
    run_line(1'b0, 1'b0, -1, -1, "R7", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule